// File: doc/BRIEF.md
# Descriptor Chain Walker for a DMA Channel

This block sequences one DMA channel through a chain of descriptors held in system memory. The source side is contiguous and the destination side is linked. Software sets a source address and the address of the first descriptor, then turns the channel on. The engine reads each five-word descriptor over a simple request/acknowledge memory port. It hands the buffer to an external data mover. When the mover reports that the buffer is complete, the engine writes the control-A word back, with its completion flag set, to the descriptor slot it came from. It then follows the next pointer until it finds a null one.

The low two bits of every descriptor pointer select a memory layer. The high bits give the word-aligned base address. Fetch and write-back for a descriptor both use that descriptor's layer. Two sticky status bits, one for a finished buffer and one for a finished chain, are cleared when software reads them.

Top module: `lldma_chain_walker`

## Requirements
- R1: Fetching starts only while the channel-enable register (index 1, bit 0) and the global-enable register (index 0, bit 0) are both 1. With the global enable at 0, a set channel enable issues no memory request.
- R2: The first descriptor base is the pointer register (index 3) with bits [1:0] masked. Each descriptor is read as five single-word reads at base+0x0, +0x4, +0x8, +0xC and +0x10, in that order. Each request holds its address until `mem_ack`.
- R3: The word at base+0x0 is discarded, and `xfer_src` always equals the source register (index 2).
- R4: One cycle after the fifth read is acknowledged, `xfer_start` pulses for one cycle. During that pulse, `xfer_dst`, `xfer_ctla` and `xfer_ctlb` carry the words read from base+0x4, +0xC and +0x10.
- R5: The cycle after `xfer_done`, the engine writes the control-A word with bit 31 set to base+0xC. The write carries the same `mem_layer` as the fetch of that descriptor.
- R6: After write-back, a next pointer (word +0x8) with nonzero bits [31:2] is fetched as the next descriptor, with bits [1:0] giving its layer. A zero pointer ends the chain: status bit 1 is set and the channel-enable bit reads 0.
- R7: Each `xfer_done` sets status bit 0.
- R8: Reading the status register (index 4) returns the pending bits and clears them, so an immediate second read returns 0.
- R9: Clearing the channel enable while a buffer is in flight lets that buffer finish and be written back. No further descriptor is fetched, and status bit 1 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (clears status on index 4) |
| cfg_addr | input | 3 | Register index: 0 global enable, 1 channel enable, 2 source, 3 descriptor pointer, 4 status |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational on `cfg_addr` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write-back, 0 for descriptor read |
| mem_addr | output | 32 | Byte address of the word |
| mem_layer | output | 2 | Memory layer of the current descriptor |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Completes the current word at this clock edge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| xfer_start | output | 1 | One-cycle pulse launching a buffer |
| xfer_src | output | 32 | Source address of the buffer |
| xfer_dst | output | 32 | Destination address of the buffer |
| xfer_ctla | output | 32 | Control-A word of the buffer |
| xfer_ctlb | output | 32 | Control-B word of the buffer |
| xfer_done | input | 1 | Pulse from the mover: buffer complete |

## Verification
`xfer_start` is due one cycle after the fifth read acknowledge. The write-back request is due the cycle after `xfer_done`. Status bits become visible on the read port the cycle after the event that sets them. The bench's memory and mover models answer on falling edges and log every completed word and launch as it happens. Each scenario waits for a known count of logged write-backs plus a few settling cycles, and then compares the logs and register reads against values built from the descriptors it placed. No check depends on a guessed cycle number.

// File: rtl/lldma_chain_walker.sv
module lldma_chain_walker #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int DONE_BIT = 31,
  parameter int RW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_re,
  input  logic [RW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_layer,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          xfer_start,
  output logic [AW-1:0] xfer_src,
  output logic [AW-1:0] xfer_dst,
  output logic [DW-1:0] xfer_ctla,
  output logic [DW-1:0] xfer_ctlb,
  input  logic          xfer_done
);
  localparam logic [RW-1:0] A_GEN  = RW'(0);
  localparam logic [RW-1:0] A_CHEN = RW'(1);
  localparam logic [RW-1:0] A_SRC  = RW'(2);
  localparam logic [RW-1:0] A_PTR  = RW'(3);
  localparam logic [RW-1:0] A_STAT = RW'(4);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_START, S_XFER, S_WB} st_t;
  st_t state;

  logic          gen_en, ch_en;
  logic [AW-1:0] src_r, ptr_r, cur, w_dst, w_next;
  logic [DW-1:0] w_ctla, w_ctlb;
  logic [2:0]    widx;
  logic [1:0]    status;

  wire [AW-1:0] base      = {cur[AW-1:2], 2'b00};
  wire          go        = gen_en && ch_en;
  wire          last      = (w_next[AW-1:2] == '0);
  wire          set_buf   = (state == S_XFER) && xfer_done;
  wire          set_chain = (state == S_WB) && mem_ack && last;
  wire          stat_rd   = cfg_re && (cfg_addr == A_STAT);

  assign mem_req    = (state == S_FETCH) || (state == S_WB);
  assign mem_we     = (state == S_WB);
  assign mem_addr   = base + ((state == S_WB) ? AW'(12) : AW'({widx, 2'b00}));
  assign mem_layer  = cur[1:0];
  assign mem_wdata  = w_ctla | (DW'(1) << DONE_BIT);
  assign xfer_start = (state == S_START);
  assign xfer_src   = src_r;
  assign xfer_dst   = w_dst;
  assign xfer_ctla  = w_ctla;
  assign xfer_ctlb  = w_ctlb;

  always_comb begin
    case (cfg_addr)
      A_GEN:   cfg_rdata = DW'(gen_en);
      A_CHEN:  cfg_rdata = DW'(ch_en);
      A_SRC:   cfg_rdata = DW'(src_r);
      A_PTR:   cfg_rdata = DW'(ptr_r);
      A_STAT:  cfg_rdata = DW'(status);
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      gen_en <= 1'b0;
      ch_en  <= 1'b0;
      src_r  <= '0;
      ptr_r  <= '0;
      cur    <= '0;
      w_dst  <= '0;
      w_next <= '0;
      w_ctla <= '0;
      w_ctlb <= '0;
      widx   <= '0;
      status <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          A_GEN:   gen_en <= cfg_wdata[0];
          A_CHEN:  ch_en  <= cfg_wdata[0];
          A_SRC:   src_r  <= AW'(cfg_wdata);
          A_PTR:   ptr_r  <= AW'(cfg_wdata);
          default: ;
        endcase
      end
      status <= (stat_rd ? 2'b00 : status) | {set_chain, set_buf};
      case (state)
        S_IDLE: if (go) begin
          cur   <= ptr_r;
          widx  <= '0;
          state <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          case (widx)
            3'd1:    w_dst  <= AW'(mem_rdata);
            3'd2:    w_next <= AW'(mem_rdata);
            3'd3:    w_ctla <= mem_rdata;
            3'd4:    w_ctlb <= mem_rdata;
            default: ;
          endcase
          if (widx == 3'd4) state <= S_START;
          else              widx  <= widx + 3'd1;
        end
        S_START: state <= S_XFER;
        S_XFER:  if (xfer_done) state <= S_WB;
        S_WB: if (mem_ack) begin
          if (last) begin
            ch_en <= 1'b0;
            state <= S_IDLE;
          end else if (ch_en) begin
            cur   <= w_next;
            widx  <= '0;
            state <= S_FETCH;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_NO_FETCH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !go) |=> !mem_req); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R4
  AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    set_buf |=> (mem_req && mem_we)); // R5
  AST_CHAIN_END_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (set_chain && !cfg_we) |=> !ch_en); // R6
  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !set_buf && !set_chain) |=> (status == 2'b00)); // R8
endmodule

// File: tb/tb_lldma_chain_walker.sv
module tb_lldma_chain_walker;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cfg_re = 0;
  logic [2:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [1:0]  mem_layer;
  logic        xfer_start, xfer_done = 0;
  logic [31:0] xfer_src, xfer_dst, xfer_ctla, xfer_ctlb;

  always #4 clk = ~clk;

  lldma_chain_walker dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [64];
  int rd_addr [64];
  int rd_n = 0;
  logic [31:0] wr_addr [8], wr_data [8];
  logic [1:0]  wr_layer [8];
  int wr_n = 0;
  logic [31:0] xs_src [8], xs_dst [8], xs_ctla [8], xs_ctlb [8];
  int x_n = 0;
  int slow = 0, tick = 0, cd = 0, done_dly = 3;

  always @(negedge clk) begin
    tick++;
    xfer_done = 0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) xfer_done = 1;
    end
    if (xfer_start && x_n < 8) begin
      xs_src[x_n] = xfer_src; xs_dst[x_n] = xfer_dst;
      xs_ctla[x_n] = xfer_ctla; xs_ctlb[x_n] = xfer_ctlb;
      x_n++;
      cd = done_dly;
    end
    if (mem_req && !mem_ack && (slow == 0 || tick % 3 == 0)) begin
      mem_ack = 1;
      if (mem_we) begin
        mem[mem_addr[7:2]] = mem_wdata;
        if (wr_n < 8) begin
          wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_wdata;
          wr_layer[wr_n] = mem_layer; wr_n++;
        end
      end else begin
        mem_rdata = mem[mem_addr[7:2]];
        if (rd_n < 64) begin rd_addr[rd_n] = int'(mem_addr); rd_n++; end
      end
    end else mem_ack = 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_re = 1; cfg_addr = a;
    #1 d = cfg_rdata;
    @(negedge clk); cfg_re = 0;
  endtask

  task automatic clear_logs();
    rd_n = 0; wr_n = 0; x_n = 0;
  endtask

  task automatic put_desc(input int base, input logic [31:0] dst, input logic [31:0] nxt,
                          input logic [31:0] ca, input logic [31:0] cb);
    mem[base/4]   = 32'hDEAD_0000 | base;
    mem[base/4+1] = dst;
    mem[base/4+2] = nxt;
    mem[base/4+3] = ca;
    mem[base/4+4] = cb;
  endtask

  task automatic wait_wr(input int n);
    for (int i = 0; i < 3000 && wr_n < n; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(mem_req == 0, "R1 reset mem_req", 32'(mem_req), 0);
    chk(xfer_start == 0, "R1 reset xfer_start", 32'(xfer_start), 0);
    cfg_read(3'd4, v);
    chk(v == 0, "R8 reset status", v, 0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    clear_logs();
    put_desc(32'h40, 32'h2000_0000, 0, 32'h11, 32'h22);
    cfg_write(3'd2, 32'h1000_0000);
    cfg_write(3'd3, 32'h40);
    cfg_write(3'd1, 1);
    repeat (20) @(negedge clk);
    chk(rd_n == 0, "R1 no fetch with global enable off", rd_n, 0);
    cfg_write(3'd0, 1);
    wait_wr(1);
    chk(rd_n == 5, "R1 fetch after global enable", rd_n, 5);
    chk(x_n == 1, "R1 one buffer launched", x_n, 1);
    cfg_read(3'd4, v);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int bases [3] = '{32'h40, 32'h80, 32'hC0};
    logic [1:0] lay [3] = '{2'd1, 2'd2, 2'd0};
    clear_logs();
    put_desc(32'h40, 32'h3000_0000, 32'h82, 32'h0000_0101, 32'hB000_0001);
    put_desc(32'h80, 32'h3100_0000, 32'hC0, 32'h0000_0202, 32'hB000_0002);
    put_desc(32'hC0, 32'h3200_0000, 32'h0,  32'h0000_0303, 32'hB000_0003);
    cfg_write(3'd2, 32'h1234_0000);
    cfg_write(3'd3, 32'h41);
    cfg_write(3'd1, 1);
    wait_wr(3);
    chk(rd_n == 15, "R2 fifteen reads for three descriptors", rd_n, 15);
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 5; j++)
        chk(rd_addr[5*k+j] == bases[k] + 4*j, "R2 read order", rd_addr[5*k+j], bases[k] + 4*j);
    end
    chk(x_n == 3, "R6 three buffers along chain", x_n, 3);
    for (int k = 0; k < 3; k++) begin
      chk(xs_src[k] == 32'h1234_0000, "R3 source from register", xs_src[k], 32'h1234_0000);
      chk(xs_dst[k] == 32'h3000_0000 + 32'(k) * 32'h0100_0000, "R4 destination", xs_dst[k],
          32'h3000_0000 + 32'(k) * 32'h0100_0000);
      chk(xs_ctla[k] == 32'h101 * 32'(k+1), "R4 control A", xs_ctla[k], 32'h101 * 32'(k+1));
      chk(xs_ctlb[k] == 32'hB000_0001 + 32'(k), "R4 control B", xs_ctlb[k], 32'hB000_0001 + 32'(k));
      chk(wr_addr[k] == 32'(bases[k] + 12), "R5 writeback address", wr_addr[k], 32'(bases[k] + 12));
      chk(wr_data[k] == (32'h8000_0000 | 32'h101 * 32'(k+1)), "R5 writeback data", wr_data[k],
          32'h8000_0000 | 32'h101 * 32'(k+1));
      chk(wr_layer[k] == lay[k], "R5 writeback layer", 32'(wr_layer[k]), 32'(lay[k]));
    end
    chk(mem[32'h80/4+1] == 32'h3100_0000, "R5 neighbour word untouched", mem[32'h80/4+1], 32'h3100_0000);
    cfg_read(3'd4, v);
    chk(v[0] == 1, "R7 buffer-done bit", 32'(v[0]), 1);
    chk(v[1] == 1, "R6 chain-done bit", 32'(v[1]), 1);
    cfg_read(3'd4, v);
    chk(v == 0, "R8 status cleared by read", v, 0);
    cfg_read(3'd1, v);
    chk(v == 0, "R6 channel enable cleared at chain end", v, 0);
  endtask

  task automatic t_slow();
    logic [31:0] v;
    clear_logs();
    slow = 1;
    put_desc(32'h60, 32'h4400_0000, 0, 32'h55, 32'h66);
    cfg_write(3'd3, 32'h63);
    cfg_write(3'd1, 1);
    wait_wr(1);
    chk(rd_n == 5 && rd_addr[4] == 32'h70, "R2 reads with wait states", rd_addr[4], 32'h70);
    chk(xs_dst[0] == 32'h4400_0000, "R4 destination with wait states", xs_dst[0], 32'h4400_0000);
    chk(wr_layer[0] == 2'd3, "R5 layer with wait states", 32'(wr_layer[0]), 3);
    slow = 0;
    cfg_read(3'd4, v);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    clear_logs();
    done_dly = 10;
    put_desc(32'h40, 32'h5000_0000, 32'h80, 32'h7, 32'h8);
    put_desc(32'h80, 32'h5100_0000, 32'h0,  32'h9, 32'hA);
    cfg_write(3'd3, 32'h40);
    cfg_write(3'd1, 1);
    for (int i = 0; i < 2000 && x_n < 1; i++) @(negedge clk);
    cfg_write(3'd1, 0);
    repeat (100) @(negedge clk);
    chk(x_n == 1, "R9 in-flight buffer only", x_n, 1);
    chk(wr_n == 1 && wr_addr[0] == 32'h4C, "R9 in-flight buffer written back", wr_addr[0], 32'h4C);
    chk(rd_n == 5, "R9 no further fetch", rd_n, 5);
    cfg_read(3'd4, v);
    chk(v == 1, "R9 no chain-done after stop", v, 1);
    done_dly = 3;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gate();
    t_chain();
    t_slow();
    t_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule